// File: doc/BRIEF.md
# SPI Command Word Receiver

This block is the slave end of a serial control link. A host microcontroller drives serial clock, chip select and data-in, and each frame carries one 16-bit command word. The upper four bits name a command and the lower twelve bits are its operand. When a frame is valid, the operand lands in one of two registers in the system clock domain:

- a 12-bit configuration word that selects the operating mode of the surrounding logic;
- a single trace-enable flag.

The serial side runs entirely on the host's clock. A finished word is held stable and is announced to the system clock domain by flipping a toggle bit. A synchronizer turns that toggle into a one-cycle strobe, and the decoder uses the strobe to update the selected register. There is no valid/ready handshake and no back-pressure at either edge. The host must not close a second frame until the first has been taken, which takes four system clock cycles after chip select rises. The host already sends each command on its own and waits for every transfer to finish, so it meets this rule. The outputs are plain level signals.

Top module: `spi_cmd_rx`

## Requirements
- R1: After reset, `cfg_word` is 0x000, `cfg_mode` is 0 and `trace_en` is 1.
- R2: While `spi_cs_n` is low, one bit of `spi_mosi` is sampled on each rising edge of `spi_sck`, most significant bit first. The word is committed when `spi_cs_n` rises.
- R3: Bits 15:12 of the word are the command code. Code 0x1 loads bits 11:0 into `cfg_word`.
- R4: `cfg_mode` always equals bits 8:6 of `cfg_word`.
- R5: Code 0x2 sets `trace_en` to bit 0 of the operand: operand 1 enables tracing and operand 0 disables it. Operand bits 11:1 have no effect.
- R6: A frame with fewer or more than 16 rising `spi_sck` edges is discarded, and both registers keep their values.
- R7: A frame whose command code is neither 0x1 nor 0x2 is discarded, and both registers keep their values.
- R8: A configuration command leaves `trace_en` unchanged, and a trace command leaves `cfg_word` unchanged.
- R9: Registers change only on the fourth rising edge of `clk` after `spi_cs_n` rises. They hold their old value through the first three edges. The internal commit strobe lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the host; idles low |
| spi_cs_n | input | 1 | Active-low chip select that frames one word |
| spi_mosi | input | 1 | Serial data from the host |
| cfg_word | output | 12 | Registered configuration word |
| cfg_mode | output | 3 | Major operating mode, bits 8:6 of cfg_word |
| trace_en | output | 1 | Trace-enable flag |

## Verification
Suppose the bit counter or the shift register holds a wrong value when chip select rises. The block then either drops a good word or accepts a malformed one. That error shows up at `cfg_word` or `trace_en` four system cycles later, as a missing update or an unexpected one. A fault in the decoder shows at the ports in the cycle after the strobe: the wrong register changes, or both change. A fault in the synchronizer shows as an update on the wrong edge. The checks therefore sample exactly on the third and fourth edges after chip select rises.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int unsigned WORD_W  = 16;
  localparam int unsigned OP_W    = 4;
  localparam int unsigned DATA_W  = WORD_W - OP_W;
  localparam int unsigned MODE_LSB = 6;
  localparam int unsigned MODE_W  = 3;

  typedef enum logic [OP_W-1:0] {
    OPC_SET_CFG = 4'h1,
    OPC_TRACE   = 4'h2
  } opcode_e;
endpackage

// File: rtl/spi_frame_shifter.sv
// Serial-clock domain: shifts one word per chip-select window and publishes
// it with a toggle when exactly WORD_W bits were seen.
module spi_frame_shifter #(
  parameter int unsigned WORD_W = 16,
  localparam int unsigned CNT_W = $clog2(WORD_W + 2)
) (
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic [WORD_W-1:0] word_hold,
  output logic              commit_tgl
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(WORD_W + 1);

  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  bit_cnt;

  // Chip select high holds the shifter cleared between frames.
  always_ff @(posedge spi_sck or posedge spi_cs_n) begin
    if (spi_cs_n) begin
      shreg   <= '0;
      bit_cnt <= '0;
    end else begin
      shreg <= {shreg[WORD_W-2:0], spi_mosi};
      if (bit_cnt != CNT_SAT) bit_cnt <= bit_cnt + 1'b1;
    end
  end

  // The closing edge of chip select sees the pre-clear counter value.
  always_ff @(posedge spi_cs_n or negedge rst_n) begin
    if (!rst_n) begin
      word_hold  <= '0;
      commit_tgl <= 1'b0;
    end else if (bit_cnt == CNT_FULL) begin
      word_hold  <= shreg;
      commit_tgl <= ~commit_tgl;
    end
  end
endmodule

// File: rtl/spi_toggle_sync.sv
// Brings the commit toggle into clk and turns each flip into a one-cycle
// registered strobe.
module spi_toggle_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tgl_in,
  output logic pulse
);
  logic [STAGES:0] chain;

  generate
    if (STAGES < 2) begin : g_bad_depth
      initial $error("spi_toggle_sync needs at least two stages");
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
      pulse <= 1'b0;
    end else begin
      chain <= {chain[STAGES-1:0], tgl_in};
      pulse <= chain[STAGES-1] ^ chain[STAGES];
    end
  end
endmodule

// File: rtl/spi_cmd_decoder.sv
// Splits a committed word and updates the register its opcode selects.
module spi_cmd_decoder
  import spi_cmd_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb,
  input  logic [W-1:0]      word,
  output logic [DATA_W-1:0] cfg_word,
  output logic              trace_en
);
  logic [OP_W-1:0]   opcode;
  logic [DATA_W-1:0] operand;

  assign opcode  = word[W-1 -: OP_W];
  assign operand = word[DATA_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_word <= '0;
      trace_en <= 1'b1;
    end else if (stb) begin
      case (opcode)
        OPC_SET_CFG: cfg_word <= operand;
        OPC_TRACE:   trace_en <= operand[0];
        default:     ;
      endcase
    end
  end
endmodule

// File: rtl/spi_cmd_rx.sv
module spi_cmd_rx
  import spi_cmd_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic [DATA_W-1:0] cfg_word,
  output logic [MODE_W-1:0] cfg_mode,
  output logic              trace_en
);
  logic [WORD_W-1:0] word_hold;
  logic              commit_tgl;
  logic              commit_stb;

  spi_frame_shifter #(.WORD_W(WORD_W)) u_shift (
    .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .word_hold(word_hold), .commit_tgl(commit_tgl)
  );

  spi_toggle_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .tgl_in(commit_tgl), .pulse(commit_stb)
  );

  spi_cmd_decoder #(.W(WORD_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .stb(commit_stb), .word(word_hold),
    .cfg_word(cfg_word), .trace_en(trace_en)
  );

  assign cfg_mode = cfg_word[MODE_LSB +: MODE_W];
endmodule

// File: rtl/spi_cmd_rx_chk.sv
module spi_cmd_rx_chk
  import spi_cmd_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              commit_stb,
  input logic [WORD_W-1:0] cmd_word,
  input logic [DATA_W-1:0] cfg_word,
  input logic              trace_en
);
  logic [OP_W-1:0] op;
  logic            op_known;
  assign op       = cmd_word[WORD_W-1 -: OP_W];
  assign op_known = (op == OPC_SET_CFG) || (op == OPC_TRACE);

  assert_cfg_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    commit_stb && op == OPC_SET_CFG |=> cfg_word == $past(cmd_word[DATA_W-1:0]));

  assert_trace_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    commit_stb && op == OPC_TRACE |=> trace_en == $past(cmd_word[0]));

  assert_unknown_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    commit_stb && !op_known |=> $stable(cfg_word) && $stable(trace_en));

  assert_trace_isolated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    commit_stb && op == OPC_SET_CFG |=> $stable(trace_en));

  assert_cfg_isolated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    commit_stb && op == OPC_TRACE |=> $stable(cfg_word));

  assert_cfg_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_word) |-> $past(commit_stb));

  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    commit_stb |=> !commit_stb);
endmodule

bind spi_cmd_rx spi_cmd_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .commit_stb(commit_stb), .cmd_word(word_hold),
  .cfg_word(cfg_word), .trace_en(trace_en)
);

// File: tb/tb_spi_cmd_rx.sv
`timescale 1ns/1ps
module tb_spi_cmd_rx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        spi_sck = 1'b0;
  logic        spi_cs_n = 1'b1;
  logic        spi_mosi = 1'b0;
  logic [11:0] cfg_word;
  logic [2:0]  cfg_mode;
  logic        trace_en;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  spi_cmd_rx dut (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .cfg_word(cfg_word), .cfg_mode(cfg_mode), .trace_en(trace_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Sends the low nbits of bits, MSB first; returns right after chip select rises.
  task automatic send_frame(input logic [31:0] bits, input int nbits);
    @(negedge clk);
    spi_cs_n = 1'b0;
    #20;
    for (int i = nbits - 1; i >= 0; i--) begin
      spi_mosi = bits[i];
      #20 spi_sck = 1'b1;
      #20 spi_sck = 1'b0;
    end
    #20 spi_cs_n = 1'b1;
  endtask

  task automatic settle;
    repeat (8) @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    chk("R1 cfg_word", 32'(cfg_word), 32'h000);
    chk("R1 cfg_mode", 32'(cfg_mode), 32'h0);
    chk("R1 trace_en", 32'(trace_en), 32'h1);
  endtask

  task automatic t_cfg_write;
    send_frame(32'h11C5, 16); settle();
    chk("R2 R3 cfg load", 32'(cfg_word), 32'h1C5);
    chk("R4 mode 7", 32'(cfg_mode), 32'h7);
    send_frame(32'h1A5A, 16); settle();
    chk("R2 msb-first pattern", 32'(cfg_word), 32'hA5A);
  endtask

  task automatic t_mode_field;
    send_frame(32'h10C0, 16); settle();
    chk("R4 mode 3", 32'(cfg_mode), 32'h3);
    send_frame(32'h1E3F, 16); settle();
    chk("R4 mode 0 with other bits", 32'(cfg_mode), 32'h0);
    chk("R3 cfg 0xE3F", 32'(cfg_word), 32'hE3F);
  endtask

  task automatic t_trace;
    send_frame(32'h2000, 16); settle();
    chk("R5 trace off", 32'(trace_en), 32'h0);
    send_frame(32'h2001, 16); settle();
    chk("R5 trace on", 32'(trace_en), 32'h1);
    send_frame(32'h2FFE, 16); settle();
    chk("R5 upper operand bits ignored", 32'(trace_en), 32'h0);
    send_frame(32'h2001, 16); settle();
  endtask

  task automatic t_isolation;
    send_frame(32'h1123, 16); settle();
    send_frame(32'h2000, 16); settle();
    chk("R8 cfg kept by trace cmd", 32'(cfg_word), 32'h123);
    send_frame(32'h1456, 16); settle();
    chk("R8 trace kept by cfg cmd", 32'(trace_en), 32'h0);
    send_frame(32'h2001, 16); settle();
  endtask

  task automatic t_bad_length;
    send_frame(32'h0000_1FFF, 15); settle();
    chk("R6 15-bit frame", 32'(cfg_word), 32'h456);
    send_frame(32'h0000_3FFE, 17); settle();
    chk("R6 17-bit frame", 32'(cfg_word), 32'h456);
    send_frame(32'h0000_4000, 17); settle();
    chk("R6 17-bit trace-like frame", 32'(trace_en), 32'h1);
  endtask

  task automatic t_unknown_op;
    send_frame(32'h3ABC, 16); settle();
    chk("R7 opcode 3 cfg", 32'(cfg_word), 32'h456);
    chk("R7 opcode 3 trace", 32'(trace_en), 32'h1);
    send_frame(32'h0FF0, 16); settle();
    chk("R7 opcode 0 cfg", 32'(cfg_word), 32'h456);
    send_frame(32'hF000, 16); settle();
    chk("R7 opcode F trace", 32'(trace_en), 32'h1);
  endtask

  task automatic t_latency;
    send_frame(32'h1777, 16);
    repeat (3) @(posedge clk);
    #1;
    chk("R9 unchanged at third edge", 32'(cfg_word), 32'h456);
    @(posedge clk);
    #1;
    chk("R9 updated at fourth edge", 32'(cfg_word), 32'h777);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    t_cfg_write();
    t_mode_field();
    t_trace();
    t_isolation();
    t_bad_length();
    t_unknown_op();
    t_latency();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule